// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block resolves data hazards in a five-stage integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. Its outputs steer the datapath in the same cycle that the register numbers are presented.

Forwarding works per ALU operand. The two source register numbers of the instruction in execute are compared with the destinations held in the execute/memory and memory/writeback pipeline registers. A 2-bit select is driven for each operand multiplexer. When both later stages hold a matching destination, the younger (execute/memory) result wins.

The interlock covers the one case forwarding cannot reach in time: a load in execute whose destination is a source of the instruction in decode. In that cycle the block does three things. It holds the program counter. It holds the fetch/decode register, so the same instruction is decoded again. It zeroes the control bundle entering the decode/execute register, which turns that slot into a bubble. One cycle later the load has moved to the memory stage. One cycle after that, the dependent instruction reaches execute and takes the loaded value over the memory/writeback path.

Top module: `hazard_unit`

## Requirements
- R1: Select encoding is 2'b00 = register-file value, 2'b10 = execute/memory result, 2'b01 = memory/writeback result; 2'b11 is never driven.
- R2: An operand select is 2'b10 when the execute/memory stage has its write enable set, a nonzero destination, and that destination equals the operand's source register.
- R3: When the execute/memory stage does not qualify under R2, the select is 2'b01 if the memory/writeback stage has its write enable set, a nonzero destination, and that destination equals the source register.
- R4: When both stages qualify for the same operand, the execute/memory result (2'b10) is chosen.
- R5: A stage whose destination is register 0, or whose write enable is clear, is never forwarded. The select falls through to the other stage or to 2'b00.
- R6: Operand A (`fwd_a_o`) is decided only by the execute-stage rs number, and operand B (`fwd_b_o`) only by the execute-stage rt number.
- R7: A stall is raised when the execute-stage memory-read flag is set and the execute-stage load destination equals either the decode-stage rs or the decode-stage rt.
- R8: During a stall, `pc_we_o` and `ifid_we_o` are both 0, `bubble_o` is 1 and `ctrl_o` is all zeros. Otherwise both write enables are 1, `bubble_o` is 0 and `ctrl_o` equals `ctrl_i`.
- R9: With the memory-read flag clear, no stall is raised even when the register numbers match. After a load-use stall the bubble clears the flag, so the stall lasts exactly one cycle. The dependent instruction then receives 2'b01 on the matching operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used only to sample the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| id_rs_i | input | REG_W | rs of the instruction in decode |
| id_rt_i | input | REG_W | rt of the instruction in decode |
| ex_rs_i | input | REG_W | rs carried in the decode/execute register |
| ex_rt_i | input | REG_W | rt carried in the decode/execute register |
| ex_load_i | input | 1 | Instruction in execute reads memory |
| ex_dst_i | input | REG_W | Load destination (rt) of the instruction in execute |
| mem_rd_i | input | REG_W | Destination in the execute/memory register |
| mem_we_i | input | 1 | Register-write enable in the execute/memory register |
| wb_rd_i | input | REG_W | Destination in the memory/writeback register |
| wb_we_i | input | 1 | Register-write enable in the memory/writeback register |
| ctrl_i | input | CTRL_W | Control bundle produced by decode |
| fwd_a_o | output | 2 | Select for the rs operand multiplexer |
| fwd_b_o | output | 2 | Select for the rt operand multiplexer |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| bubble_o | output | 1 | High while a bubble is being inserted |
| ctrl_o | output | CTRL_W | Control bundle into the decode/execute register |

## Verification
The bench builds the block with its defaults: `REG_W` = 5, `CTRL_W` = 9 and `ZERO_GUARD` = 1. This covers the full register space from register 0 to register 31, so both the hard-wired zero register and the highest register number are compared. A nine-bit control bundle with a distinctive nonzero pattern shows the bubble zeroing every bit. The same pattern shows the bundle passing through unchanged when there is no stall. A three-cycle walk models a load-use pair moving through the stages, and shows one stall cycle followed by forwarding from memory/writeback.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/fwd_compare.sv
module fwd_compare #(
  parameter int unsigned REG_W      = 5,
  parameter bit          ZERO_GUARD = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output logic [1:0]       sel_o
);
  import hazard_pkg::*;

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic mem_ok, wb_ok;
  logic mem_hit, wb_hit;
  fwd_sel_e sel;

  generate
    if (ZERO_GUARD) begin : g_guard
      assign mem_ok = mem_we_i && (mem_rd_i != ZERO_REG);
      assign wb_ok  = wb_we_i  && (wb_rd_i  != ZERO_REG);
    end else begin : g_noguard
      assign mem_ok = mem_we_i;
      assign wb_ok  = wb_we_i;
    end
  endgenerate

  assign mem_hit = mem_ok && (mem_rd_i == src_i);
  assign wb_hit  = wb_ok  && (wb_rd_i  == src_i);

  // younger stage first
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  assign sel_o = sel;

  assert_sel_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != 2'b11);

  assert_mem_needs_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == 2'b10) |-> (mem_we_i && mem_rd_i == src_i));

  assert_wb_needs_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == 2'b01) |-> (wb_we_i && wb_rd_i == src_i));

  generate
    if (ZERO_GUARD) begin : g_zero_chk
      assert_no_zero_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o != 2'b00) |-> (src_i != '0));
    end
  endgenerate
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] ex_dst_i,
  output logic             stall_o
);
  logic rs_dep, rt_dep;

  assign rs_dep  = (ex_dst_i == id_rs_i);
  assign rt_dep  = (ex_dst_i == id_rt_i);
  assign stall_o = ex_load_i && (rs_dep || rt_dep);

  assert_stall_needs_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ex_load_i);

  assert_stall_needs_dep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_dst_i == id_rs_i || ex_dst_i == id_rt_i));
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl #(
  parameter int unsigned CTRL_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              bubble_o
);
  assign ctrl_o    = stall_i ? '0 : ctrl_i;
  assign pc_we_o   = ~stall_i;
  assign ifid_we_o = ~stall_i;
  assign bubble_o  = stall_i;

  assert_bubble_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> (!pc_we_o && !ifid_we_o && ctrl_o == '0));

  assert_pass_through_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bubble_o |-> (pc_we_o && ifid_we_o && ctrl_o == ctrl_i));
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int unsigned REG_W      = 5,
  parameter int unsigned CTRL_W     = 9,
  parameter bit          ZERO_GUARD = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  id_rs_i,
  input  logic [REG_W-1:0]  id_rt_i,
  input  logic [REG_W-1:0]  ex_rs_i,
  input  logic [REG_W-1:0]  ex_rt_i,
  input  logic              ex_load_i,
  input  logic [REG_W-1:0]  ex_dst_i,
  input  logic [REG_W-1:0]  mem_rd_i,
  input  logic              mem_we_i,
  input  logic [REG_W-1:0]  wb_rd_i,
  input  logic              wb_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              bubble_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  import hazard_pkg::*;

  logic [REG_W-1:0] src [NUM_OPS];
  logic [1:0]       sel [NUM_OPS];
  logic             stall;

  assign src[0] = ex_rs_i;
  assign src[1] = ex_rt_i;

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      fwd_compare #(
        .REG_W      (REG_W),
        .ZERO_GUARD (ZERO_GUARD)
      ) u_cmp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .src_i    (src[i]),
        .mem_rd_i (mem_rd_i),
        .mem_we_i (mem_we_i),
        .wb_rd_i  (wb_rd_i),
        .wb_we_i  (wb_we_i),
        .sel_o    (sel[i])
      );
    end
  endgenerate

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  load_use_detect #(.REG_W(REG_W)) u_lud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_rs_i   (id_rs_i),
    .id_rt_i   (id_rt_i),
    .ex_load_i (ex_load_i),
    .ex_dst_i  (ex_dst_i),
    .stall_o   (stall)
  );

  stall_ctrl #(.CTRL_W(CTRL_W)) u_stc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall),
    .ctrl_i    (ctrl_i),
    .ctrl_o    (ctrl_o),
    .pc_we_o   (pc_we_o),
    .ifid_we_o (ifid_we_o),
    .bubble_o  (bubble_o)
  );

  // younger result must win when both stages target operand A
  assert_mem_priority_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && mem_rd_i != '0 && mem_rd_i == ex_rs_i && wb_we_i && wb_rd_i == ex_rs_i)
      |-> (fwd_a_o == 2'b10));

  assert_enables_agree_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o == ifid_we_o);

  // the bubble clears the load flag in the next cycle, so no second stall
  assert_single_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bubble_o) && !ex_load_i) |-> !bubble_o);
endmodule

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned CTRL_W = 9;
  localparam int unsigned NV     = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [REG_W-1:0]  id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_rd, wb_rd;
  logic              ex_load, mem_we, wb_we;
  logic [CTRL_W-1:0] ctrl_in, ctrl_out;
  logic [1:0]        fwd_a, fwd_b;
  logic              pc_we, ifid_we, bubble;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hazard_unit #(.REG_W(REG_W), .CTRL_W(CTRL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_rs_i(id_rs), .id_rt_i(id_rt), .ex_rs_i(ex_rs), .ex_rt_i(ex_rt),
    .ex_load_i(ex_load), .ex_dst_i(ex_dst),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .ctrl_i(ctrl_in), .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_o(bubble), .ctrl_o(ctrl_out)
  );

  // {ex_rs, ex_rt, mem_rd, mem_we, wb_rd, wb_we, exp_a, exp_b}
  localparam logic [25:0] VEC [NV] = '{
    {5'd2,  5'd3,  5'd2,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00}, // R2 back-to-back
    {5'd4,  5'd2,  5'd7,  1'b1, 5'd2,  1'b1, 2'b00, 2'b01}, // R3 two apart
    {5'd2,  5'd2,  5'd2,  1'b1, 5'd2,  1'b1, 2'b10, 2'b10}, // R4 priority
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R5 reg 0
    {5'd5,  5'd6,  5'd5,  1'b0, 5'd6,  1'b0, 2'b00, 2'b00}, // R5 we off
    {5'd31, 5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 2'b01, 2'b01}, // R3 top reg
    {5'd8,  5'd9,  5'd9,  1'b1, 5'd8,  1'b1, 2'b01, 2'b10}, // R6 split
    {5'd0,  5'd3,  5'd0,  1'b1, 5'd3,  1'b1, 2'b00, 2'b01}, // R5 mem r0
    {5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1, 2'b00, 2'b00}, // R1 no match
    {5'd7,  5'd7,  5'd7,  1'b0, 5'd7,  1'b1, 2'b01, 2'b01}  // R5 fall to wb
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs = '0; id_rt = '0; ex_rs = '0; ex_rt = '0; ex_dst = '0;
    mem_rd = '0; wb_rd = '0; ex_load = 1'b0; mem_we = 1'b0; wb_we = 1'b0;
    ctrl_in = 9'h1A5;
  endtask

  task automatic chk_stall(input string req, input bit st);
    chk(req, {28'd0, pc_we, ifid_we, bubble, 1'b0}, {28'd0, ~st, ~st, st, 1'b0});
    chk(req, {23'd0, ctrl_out}, st ? 32'd0 : {23'd0, ctrl_in});
  endtask

  initial begin
    idle();
    #1;
    // reset state: no forwarding, no stall
    chk("R1 reset fwd", {30'd0, fwd_a}, 32'd0);
    chk("R1 reset fwd", {30'd0, fwd_b}, 32'd0);
    chk_stall("R8 reset", 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < int'(NV); i++) begin
      @(negedge clk);
      {ex_rs, ex_rt, mem_rd, mem_we, wb_rd, wb_we} = VEC[i][25:4];
      #1;
      chk($sformatf("R2-table row %0d A", i), {30'd0, fwd_a}, {30'd0, VEC[i][3:2]});
      chk($sformatf("R6 table row %0d B", i), {30'd0, fwd_b}, {30'd0, VEC[i][1:0]});
    end

    // R7 load-use on rs
    @(negedge clk); idle();
    ex_load = 1'b1; ex_dst = 5'd4; id_rs = 5'd4; id_rt = 5'd9;
    #1; chk_stall("R7 rs dep", 1'b1);
    // R7 load-use on rt
    @(negedge clk); id_rs = 5'd1; id_rt = 5'd4;
    #1; chk_stall("R7 rt dep", 1'b1);
    // R7 independent
    @(negedge clk); id_rt = 5'd5;
    #1; chk_stall("R7 no dep", 1'b0);
    // R9 match but not a load
    @(negedge clk); ex_load = 1'b0; id_rs = 5'd4;
    #1; chk_stall("R9 not load", 1'b0);

    // R9 pipeline walk: lw r6 ; add r7,r6,r2
    @(negedge clk); idle();
    ex_load = 1'b1; ex_dst = 5'd6; ex_rt = 5'd6; id_rs = 5'd6; id_rt = 5'd2;
    #1; chk_stall("R9 walk stall", 1'b1);
    @(negedge clk); // bubble in ex, load in mem, add held in decode
    ex_load = 1'b0; ex_dst = 5'd0; ex_rs = 5'd0; ex_rt = 5'd0;
    mem_rd = 5'd6; mem_we = 1'b1;
    #1; chk_stall("R9 walk one cycle", 1'b0);
    @(negedge clk); // add in ex, bubble in mem, load in wb
    ex_rs = 5'd6; ex_rt = 5'd2; mem_rd = 5'd0; mem_we = 1'b0;
    wb_rd = 5'd6; wb_we = 1'b1; id_rs = 5'd3; id_rt = 5'd3;
    #1;
    chk("R9 walk fwd A", {30'd0, fwd_a}, 32'd1);
    chk("R9 walk fwd B", {30'd0, fwd_b}, 32'd0);

    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule